// File: doc/BRIEF.md
# MDIO Management Master with Address Scan

This block is the station-management master for an Ethernet PHY. It takes single read and single write commands from the host side and serialises each one as a clause-22 management frame. Each frame carries a PHY address, a register address and, for writes, 16 data bits. The management clock is made by dividing the host clock. A three-bit selector picks the divisor from a fixed, non-uniform set.

The slow divisors keep the management clock at or below 2.5 MHz for ordinary PHYs. The fast ones serve PHYs that accept up to 12.5 MHz. The 32-bit all-ones preamble can be left out for PHYs that tolerate shortened frames.

Holding the repeat request while issuing a read keeps the master reading. With the scan option clear, it reads the same PHY again and again. With the scan option set, it walks the PHY address from 1 up to the programmed address, then starts again at 1. Each completed read raises a one-cycle valid strobe with the data and the PHY address it came from. A soft-reset input drops the engine to idle at once.

Top module: `mdio_master`

## Requirements
- R1: The selector `cfg_div_sel` sets the management-clock period N in host cycles: 000 and 001 give 4, 010 gives 6, 011 gives 8, 100 gives 10, 101 gives 14, 110 gives 20 and 111 gives 28. `mdc` is high for exactly N/2 cycles of each period.
- R2: With the preamble enabled, a frame is 64 bits, sent MSB-first and sampled by the PHY on the rising edge of `mdc`. The bits are: 32 ones, start `01`, opcode (`10` read, `01` write), PHY address (5 bits, MSB first), register address (5 bits), turnaround, then 16 data bits. A write drives turnaround `10` followed by the write data.
- R3: With `cfg_no_preamble` high, the 32 preamble ones are omitted and the frame is 32 bits.
- R4: During a read, `mdio_oe` is low for the two turnaround bits and the 16 data bits. Data is captured from `mdio_i` on the rising edges of `mdc`. When the frame ends, `rd_valid` pulses for one cycle with `rd_data` and `rd_phy`.
- R5: `mdio_o` and `mdio_oe` change only while `mdc` is low. They never change during the high phase or on its rising edge.
- R6: `busy` rises on the edge that accepts a command and stays high for exactly N times the frame length in cycles.
- R7: A read or write request made while `busy` is high has no effect. No extra frame is sent and the current frame is unchanged.
- R8: A read accepted with `cmd_repeat` high and `cfg_scan_inc` low reads the same PHY address repeatedly, back to back.
- R9: A read accepted with `cmd_repeat` and `cfg_scan_inc` high reads PHY addresses 1, 2, ..., up to `cmd_phy`, then wraps to 1. If `cmd_phy` is 1 or lower, every read uses address 1.
- R10: Dropping `cmd_repeat` ends the sequence after the frame in progress completes. `cmd_repeat` has no effect on a write.
- R11: After reset, and one cycle after `cfg_soft_reset` is high, `busy`, `mdc`, `mdio_oe` and `rd_valid` are low. No pending read result is ever reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_div_sel | input | 3 | Management clock divisor selector |
| cfg_no_preamble | input | 1 | Omit the 32-bit preamble |
| cfg_scan_inc | input | 1 | Walk PHY addresses during repeated reads |
| cfg_soft_reset | input | 1 | Return the engine to idle |
| cmd_read | input | 1 | Request a read frame |
| cmd_write | input | 1 | Request a write frame |
| cmd_repeat | input | 1 | Keep reading after each frame |
| cmd_phy | input | 5 | PHY address, or scan upper limit |
| cmd_reg | input | 5 | Register address |
| cmd_wdata | input | 16 | Write data |
| busy | output | 1 | Frame sequence in progress |
| rd_valid | output | 1 | One-cycle read-complete strobe |
| rd_data | output | 16 | Read data |
| rd_phy | output | 5 | PHY address of the read data |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Serial data out |
| mdio_oe | output | 1 | Serial data drive enable |
| mdio_i | input | 1 | Serial data in |

## Verification
The hardest situation to reach is the boundary between two frames of a repeated read. There the next PHY address must be chosen, the previous result reported and the repeat request sampled, all on one falling edge of `mdc`.

The bench includes a PHY model. It decodes the address bits it sees on the line and answers with data derived from them, so any wrong scan address shows up in both `rd_phy` and `rd_data`. The bench releases the repeat request just after a chosen result appears, which lands in the middle of the following frame, and checks that exactly one more frame follows. A scan limit of 1 is also exercised to hit the wrap condition on every frame.

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int PHY_W   = 5,
  parameter int REG_W   = 5,
  parameter int DATA_W  = 16,
  parameter int PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cfg_div_sel,
  input  logic              cfg_no_preamble,
  input  logic              cfg_scan_inc,
  input  logic              cfg_soft_reset,
  input  logic              cmd_read,
  input  logic              cmd_write,
  input  logic              cmd_repeat,
  input  logic [PHY_W-1:0]  cmd_phy,
  input  logic [REG_W-1:0]  cmd_reg,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              busy,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [PHY_W-1:0]  rd_phy,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  localparam int FLEN   = PRE_LEN + 6 + PHY_W + REG_W + DATA_W;
  localparam int IW     = $clog2(FLEN);
  localparam int TA_AT  = PRE_LEN + 4 + PHY_W + REG_W;
  localparam int DAT_AT = TA_AT + 2;
  localparam logic [IW-1:0] LAST  = IW'(FLEN - 1);
  localparam logic [IW-1:0] FIRST = IW'(PRE_LEN);

  logic [3:0]        half_q, cnt;
  logic              rd_q, scan_q, nopre_q;
  logic [PHY_W-1:0]  phy_q, lim_q, next_phy;
  logic [REG_W-1:0]  reg_q;
  logic [DATA_W-1:0] wdat_q, rx;
  logic [IW-1:0]     bidx;
  logic [FLEN-1:0]   frame;
  logic              accept, tick;

  function automatic logic [3:0] half_of(input logic [2:0] sel);
    case (sel)
      3'd2:    half_of = 4'd3;
      3'd3:    half_of = 4'd4;
      3'd4:    half_of = 4'd5;
      3'd5:    half_of = 4'd7;
      3'd6:    half_of = 4'd10;
      3'd7:    half_of = 4'd14;
      default: half_of = 4'd2;
    endcase
  endfunction

  assign frame = {{PRE_LEN{1'b1}}, 2'b01, rd_q ? 2'b10 : 2'b01, phy_q, reg_q,
                  rd_q ? 2'b00 : 2'b10, rd_q ? {DATA_W{1'b0}} : wdat_q};
  assign mdio_o   = busy & frame[LAST - bidx];
  assign mdio_oe  = busy & ~(rd_q & (bidx >= IW'(TA_AT)));
  assign accept   = !busy && (cmd_read || cmd_write) && !cfg_soft_reset;
  assign tick     = busy && (cnt == half_q - 4'd1);
  assign next_phy = !scan_q ? phy_q :
                    (phy_q >= lim_q) ? PHY_W'(1) : phy_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; mdc <= 1'b0; cnt <= '0; bidx <= '0;
      rd_valid <= 1'b0; rd_data <= '0; rd_phy <= '0; rx <= '0;
      half_q <= 4'd2; rd_q <= 1'b0; scan_q <= 1'b0; nopre_q <= 1'b0;
      phy_q <= '0; lim_q <= '0; reg_q <= '0; wdat_q <= '0;
    end else begin
      rd_valid <= 1'b0;
      if (cfg_soft_reset) begin
        busy <= 1'b0; mdc <= 1'b0; cnt <= '0;
      end else if (accept) begin
        busy    <= 1'b1;
        mdc     <= 1'b0;
        cnt     <= '0;
        half_q  <= half_of(cfg_div_sel);
        rd_q    <= cmd_read;
        scan_q  <= cmd_read & cfg_scan_inc;
        nopre_q <= cfg_no_preamble;
        phy_q   <= (cmd_read && cfg_scan_inc) ? PHY_W'(1) : cmd_phy;
        lim_q   <= cmd_phy;
        reg_q   <= cmd_reg;
        wdat_q  <= cmd_wdata;
        bidx    <= cfg_no_preamble ? FIRST : '0;
      end else if (tick) begin
        cnt <= '0;
        mdc <= ~mdc;
        if (!mdc) begin
          if (rd_q && bidx >= IW'(DAT_AT)) rx <= {rx[DATA_W-2:0], mdio_i};
        end else if (bidx != LAST) begin
          bidx <= bidx + 1'b1;
        end else begin
          if (rd_q) begin
            rd_valid <= 1'b1;
            rd_data  <= rx;
            rd_phy   <= phy_q;
          end
          if (rd_q && cmd_repeat) begin
            phy_q <= next_phy;
            bidx  <= nopre_q ? FIRST : '0;
          end else begin
            busy <= 1'b0;
          end
        end
      end else if (busy) begin
        cnt <= cnt + 4'd1;
      end
    end
  end
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
  parameter int PHY_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_soft_reset,
  input logic             cmd_read,
  input logic             cmd_write,
  input logic             busy,
  input logic             rd_valid,
  input logic             mdc,
  input logic             mdio_o,
  input logic             mdio_oe,
  input logic             scan_q,
  input logic [PHY_W-1:0] rd_phy,
  input logic [PHY_W-1:0] lim_q
);
  p_pin_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy && mdc |-> $stable(mdio_o) && $stable(mdio_oe));

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc && !mdio_oe);

  p_soft_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_soft_reset |=> !busy && !rd_valid);

  p_start_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_read || cmd_write));

  p_valid_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  p_valid_at_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !mdc);

  p_scan_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && scan_q |-> rd_phy != '0 && (rd_phy <= lim_q || rd_phy == PHY_W'(1)));
endmodule

bind mdio_master mdio_master_chk #(.PHY_W(PHY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_soft_reset(cfg_soft_reset),
  .cmd_read(cmd_read), .cmd_write(cmd_write), .busy(busy),
  .rd_valid(rd_valid), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
  .scan_q(scan_q), .rd_phy(rd_phy), .lim_q(lim_q)
);

// File: tb/mdio_master_bench.sv
module mdio_master_bench;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] cfg_div_sel = 3'd0;
  logic cfg_no_preamble = 1'b0, cfg_scan_inc = 1'b0, cfg_soft_reset = 1'b0;
  logic cmd_read = 1'b0, cmd_write = 1'b0, cmd_repeat = 1'b0;
  logic [4:0] cmd_phy = '0, cmd_reg = '0;
  logic [15:0] cmd_wdata = '0;
  logic busy, rd_valid, mdc, mdio_o, mdio_oe, mdio_i;
  logic [15:0] rd_data;
  logic [4:0] rd_phy;

  int total = 0, failed = 0;

  mdio_master u_mdio_master (
    .clk(clk), .rst_n(rst_n), .cfg_div_sel(cfg_div_sel),
    .cfg_no_preamble(cfg_no_preamble), .cfg_scan_inc(cfg_scan_inc),
    .cfg_soft_reset(cfg_soft_reset), .cmd_read(cmd_read), .cmd_write(cmd_write),
    .cmd_repeat(cmd_repeat), .cmd_phy(cmd_phy), .cmd_reg(cmd_reg),
    .cmd_wdata(cmd_wdata), .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_phy(rd_phy), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic int ndiv(input logic [2:0] s);
    case (s)
      3'd2: ndiv = 6;  3'd3: ndiv = 8;  3'd4: ndiv = 10;
      3'd5: ndiv = 14; 3'd6: ndiv = 20; 3'd7: ndiv = 28;
      default: ndiv = 4;
    endcase
  endfunction

  function automatic logic [15:0] fdat(input logic [4:0] p, input logic [4:0] r);
    fdat = {p, r, p ^ r, 1'b1};
  endfunction

  // PHY model and line monitor
  int rc = 0, since = 0, cur_n = 4, per_err = 0, oe_cnt = 0, frame_oe = 0, frames = 0, vcnt = 0;
  logic seen = 1'b0, prev_mdc = 1'b0;
  logic [63:0] cap = '0, frame_cap = '0;
  logic [4:0] m_phy = '0, m_reg = '0;
  logic [4:0] vphy [16];
  logic [15:0] vdat [16];
  int pre_b, mi_idx;
  logic [15:0] dv;

  assign pre_b  = cfg_no_preamble ? 0 : 32;
  assign mi_idx = pre_b + 31 - rc;
  assign dv     = fdat(m_phy, m_reg);
  assign mdio_i = (rc >= pre_b + 16 && rc < pre_b + 32) ? dv[mi_idx[3:0]] : 1'b1;

  always @(negedge clk) begin
    prev_mdc <= mdc;
    if (rd_valid) begin
      vphy[vcnt % 16] <= rd_phy;
      vdat[vcnt % 16] <= rd_data;
      vcnt <= vcnt + 1;
    end
    if (!busy) begin
      rc <= 0; cap <= '0; oe_cnt <= 0; since <= 0; seen <= 1'b0;
    end else if (mdc && !prev_mdc) begin
      if (seen && since != cur_n) per_err <= per_err + 1;
      seen  <= 1'b1;
      since <= 1;
      if (rc >= pre_b + 4 && rc < pre_b + 9)  m_phy <= {m_phy[3:0], mdio_o};
      if (rc >= pre_b + 9 && rc < pre_b + 14) m_reg <= {m_reg[3:0], mdio_o};
      if (rc + 1 == pre_b + 32) begin
        frame_cap <= {cap[62:0], mdio_o};
        frame_oe  <= oe_cnt + int'(mdio_oe);
        frames    <= frames + 1;
        rc <= 0; cap <= '0; oe_cnt <= 0;
      end else begin
        cap    <= {cap[62:0], mdio_o};
        oe_cnt <= oe_cnt + int'(mdio_oe);
        rc     <= rc + 1;
      end
    end else begin
      if (!mdc && prev_mdc && since != cur_n / 2) per_err <= per_err + 1;
      since <= since + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_frame(input bit rd, input logic [2:0] sel, input bit np,
                           input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] wd);
    int f0, v0, e0, c, len;
    logic [63:0] exp, mask;
    @(negedge clk);
    cfg_div_sel = sel; cfg_no_preamble = np; cfg_scan_inc = 1'b0; cur_n = ndiv(sel);
    cmd_phy = phy; cmd_reg = rg; cmd_wdata = wd;
    cmd_read = rd; cmd_write = !rd;
    f0 = frames; v0 = vcnt; e0 = per_err;
    @(negedge clk);
    cmd_read = 1'b0; cmd_write = 1'b0;
    c = 0;
    while (busy) begin c++; @(negedge clk); end
    @(negedge clk);
    len  = np ? 32 : 64;
    exp  = {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, phy, rg, rd ? 2'b00 : 2'b10, rd ? 16'h0 : wd};
    mask = (64'h1 << len) - 64'h1;
    if (rd) mask = mask & ~64'h3FFFF;
    check(c == cur_n * len, "R6", "busy cycles", c, cur_n * len);
    check(per_err == e0, "R1", "mdc period/high phase errors", per_err - e0, 0);
    check(frames == f0 + 1, np ? "R3" : "R2", "frame count", frames - f0, 1);
    check((frame_cap & mask) == (exp & mask), np ? "R3" : "R2", "frame bits",
          frame_cap & mask, exp & mask);
    check(frame_oe == (rd ? len - 18 : len), "R4", "driven bits", frame_oe, rd ? len - 18 : len);
    if (rd) begin
      check(vcnt == v0 + 1, "R4", "valid pulses", vcnt - v0, 1);
      check(vdat[v0 % 16] == fdat(phy, rg), "R4", "read data", vdat[v0 % 16], fdat(phy, rg));
      check(vphy[v0 % 16] == phy, "R4", "read phy", vphy[v0 % 16], phy);
    end else begin
      check(vcnt == v0, "R4", "no valid on write", vcnt - v0, 0);
    end
  endtask

  task automatic run_repeat(input bit scan, input logic [4:0] phy, input logic [4:0] rg, input int stop_after);
    int v0;
    logic [4:0] ep;
    @(negedge clk);
    cfg_div_sel = 3'd0; cfg_no_preamble = 1'b1; cfg_scan_inc = scan; cur_n = 4;
    cmd_phy = phy; cmd_reg = rg; cmd_repeat = 1'b1; cmd_read = 1'b1;
    v0 = vcnt;
    @(negedge clk);
    cmd_read = 1'b0;
    while (vcnt < v0 + stop_after) @(negedge clk);
    cmd_repeat = 1'b0;
    while (busy) @(negedge clk);
    @(negedge clk);
    check(vcnt == v0 + stop_after + 1, "R10", "reads after release", vcnt - v0, stop_after + 1);
    for (int i = 0; i <= stop_after; i++) begin
      if (scan) ep = (phy <= 5'd1) ? 5'd1 : 5'(1 + (i % int'(phy)));
      else      ep = phy;
      check(vphy[(v0 + i) % 16] == ep, scan ? "R9" : "R8", "sequence phy", vphy[(v0 + i) % 16], ep);
      check(vdat[(v0 + i) % 16] == fdat(ep, rg), scan ? "R9" : "R8", "sequence data",
            vdat[(v0 + i) % 16], fdat(ep, rg));
    end
    cfg_scan_inc = 1'b0;
  endtask

  initial begin
    #(CLK_P * 150000);
    failed++; total++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    int f0, v0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !mdc && !mdio_oe && !rd_valid, "R11", "reset state",
          {busy, mdc, mdio_oe, rd_valid}, 0);

    for (int s = 0; s < 8; s++)
      for (int np = 0; np < 2; np++)
        for (int rd = 0; rd < 2; rd++)
          run_frame(rd[0], 3'(s), np[0], 5'(s * 3 + np + 1), 5'(31 - s * 2 - rd),
                    16'hA5C3 ^ 16'(s * 4097 + np * 257 + rd));

    // R7: request while busy
    @(negedge clk);
    cfg_div_sel = 3'd0; cfg_no_preamble = 1'b0; cur_n = 4;
    cmd_phy = 5'd4; cmd_reg = 5'd2; cmd_wdata = 16'h1234; cmd_write = 1'b1;
    f0 = frames; v0 = vcnt;
    @(negedge clk); cmd_write = 1'b0;
    repeat (50) @(negedge clk);
    cmd_read = 1'b1; cmd_phy = 5'd9; cmd_reg = 5'd9; cmd_wdata = 16'hFFFF;
    @(negedge clk); cmd_read = 1'b0;
    while (busy) @(negedge clk);
    @(negedge clk);
    check(frame_cap == {32'hFFFF_FFFF, 2'b01, 2'b01, 5'd4, 5'd2, 2'b10, 16'h1234}, "R7",
          "frame unchanged", frame_cap, {32'hFFFF_FFFF, 2'b01, 2'b01, 5'd4, 5'd2, 2'b10, 16'h1234});
    repeat (300) @(negedge clk);
    check(frames == f0 + 1 && vcnt == v0 && !busy, "R7", "no extra frame", frames - f0, 1);

    // R10: repeat has no effect on write
    @(negedge clk);
    f0 = frames;
    cmd_repeat = 1'b1; cmd_write = 1'b1;
    @(negedge clk); cmd_write = 1'b0;
    while (busy) @(negedge clk);
    repeat (300) @(negedge clk);
    check(frames == f0 + 1 && !busy, "R10", "write with repeat", frames - f0, 1);
    cmd_repeat = 1'b0;

    run_repeat(1'b0, 5'd7, 5'd3, 3);
    run_repeat(1'b1, 5'd3, 5'd5, 5);
    run_repeat(1'b1, 5'd1, 5'd6, 2);

    // R11: soft reset mid-frame
    @(negedge clk);
    cfg_div_sel = 3'd0; cfg_no_preamble = 1'b0; cur_n = 4;
    cmd_phy = 5'd2; cmd_reg = 5'd1; cmd_read = 1'b1;
    v0 = vcnt;
    @(negedge clk); cmd_read = 1'b0;
    repeat (100) @(negedge clk);
    cfg_soft_reset = 1'b1;
    @(negedge clk); cfg_soft_reset = 1'b0;
    check(!busy && !mdc && !mdio_oe, "R11", "idle after soft reset", {busy, mdc, mdio_oe}, 0);
    repeat (2000) @(negedge clk);
    check(vcnt == v0 && !busy, "R11", "no result after soft reset", vcnt - v0, 0);
    run_frame(1'b1, 3'd1, 1'b0, 5'd17, 5'd30, 16'h0);

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule